// File: doc/BRIEF.md
# Reloadable Down-Counter Timer with Underflow Interrupt

This block is a small programmable timer meant to sit on a microcontroller's byte-wide register bus. A counter counts down once per pulse from an external prescaler. When it is at zero and another pulse arrives, it underflows and reloads itself from a reload register. The period is therefore the reload value plus one prescaler pulse. Software loads the counter on demand through a preset strobe, and it can stop and resume the count with a run bit. A stop does not lose the count.

Each underflow flips an internal toggle. That toggle can be gated out as a clock at half the underflow rate, for a serial interface. Each underflow also latches a factor flag, which software clears by writing a one to it. An interrupt request goes to the CPU only when three things hold: the flag is set, the enable bit is set, and the programmed 2-bit priority is strictly above the CPU's present mask level. The request carries that priority as its level.

Top module: `reload_timer`

## Requirements
- R1: After reset, the reload, run, clock-output enable, priority, interrupt enable, factor flag and counter are all 0. `clk_out`, `irq_req` and `irq_level` are 0.
- R2: Register selects on `bus_addr` are: 0 reload (read/write), 1 control, 2 interrupt, 3 counter (read only). In the control register, bit 0 is run, bit 1 is preset and bit 2 is clock-output enable. Writing a control value with bit 1 set loads the reload value into the counter. Writing a control value with bit 1 clear leaves the counter unchanged. Bit 1 always reads 0.
- R3: While run is 0, the counter holds its value even when prescaler pulses arrive, and a preset value stays in place until counting starts. Setting run back to 1 resumes counting from the held value, with no reload.
- R4: While run is 1, each `cnt_tick` pulse decrements a non-zero count. A pulse at count 0 is an underflow and reloads the count. After a preset to value V, the count after k pulses is V − (k mod (V+1)).
- R5: The internal toggle flips on every underflow. `clk_out` equals that toggle while clock-output enable is 1, and is 0 while it is 0.
- R6: In the interrupt register, bits 1:0 are priority, bit 2 is enable and bit 3 is the factor flag. The flag becomes 1 on every underflow, whatever the enable and priority are. Writing 1 to bit 3 clears the flag, and writing 0 to bit 3 leaves it unchanged.
- R7: When a flag-clear write and an underflow fall in the same cycle, the flag ends up 1.
- R8: `irq_req` is 1 exactly when the flag is 1, enable is 1, and priority > `cpu_mask`. `irq_level` equals the priority while `irq_req` is 1, and is 0 otherwise. Priority 0 never requests.
- R9: When a preset write and a prescaler pulse fall in the same cycle, the preset wins. The count takes the reload value, and no underflow is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Single-cycle count-enable pulse from the prescaler |
| cpu_mask | input | 2 | CPU's current interrupt mask level |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| clk_out | output | 1 | Gated half-underflow-rate clock toward the serial interface |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 2 | Level of the pending request |

## Verification
Two pairs of events can coincide in one cycle. The first pair is an underflow and a software write that clears the flag. The second pair is a preset write and a prescaler pulse. The bench drives the bus write and `cnt_tick` together, on the same falling edge, with the counter already at zero. It then reads the flag and the count back. A clear that races an underflow must leave the flag set. A preset that races a pulse must leave the reload value in the counter and the flag clear.

// File: rtl/reload_timer_pkg.sv
`timescale 1ns/1ps
// Shared register selects and bit positions for the reload timer.
// Assumes a 2-bit register select and a data width of at least 4 bits.
package reload_timer_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_RELOAD = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_IRQ    = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_e;

    // control register bit positions
    localparam int CTL_RUN    = 0;
    localparam int CTL_PRESET = 1;
    localparam int CTL_OEN    = 2;
    // interrupt register bit positions (priority sits in the low bits)
    localparam int IRQ_IE     = 2;
    localparam int IRQ_FLAG   = 3;
endpackage

// File: rtl/reload_timer_regs.sv
`timescale 1ns/1ps
// Register file: holds the reload value, run, output enable, priority and
// interrupt enable. It decodes the preset and flag-clear strobes and muxes
// read data. Assumes a single-cycle write strobe and CW >= 4.
module reload_timer_regs
    import reload_timer_pkg::*;
#(
    parameter int CW = 8,
    parameter int PW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] addr,
    input  logic [CW-1:0]    wdata,
    input  logic [CW-1:0]    count,
    input  logic             flag,
    output logic [CW-1:0]    rdata,
    output logic [CW-1:0]    reload,
    output logic             run,
    output logic             oen,
    output logic [PW-1:0]    prio,
    output logic             ie,
    output logic             preset_stb,
    output logic             clr_stb
);
    localparam logic [SEL_W-1:0] A_RELOAD = SEL_RELOAD;
    localparam logic [SEL_W-1:0] A_CTRL   = SEL_CTRL;
    localparam logic [SEL_W-1:0] A_IRQ    = SEL_IRQ;

    // Write-one strobes, valid for the write cycle only.
    assign preset_stb = we && (addr == A_CTRL) && wdata[CTL_PRESET];
    assign clr_stb    = we && (addr == A_IRQ)  && wdata[IRQ_FLAG];

    // Capture the programmable fields on a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
            run    <= 1'b0;
            oen    <= 1'b0;
            prio   <= '0;
            ie     <= 1'b0;
        end else if (we) begin
            case (addr)
                A_RELOAD: reload <= wdata;
                A_CTRL: begin
                    run <= wdata[CTL_RUN];
                    oen <= wdata[CTL_OEN];
                end
                A_IRQ: begin
                    prio <= wdata[PW-1:0];
                    ie   <= wdata[IRQ_IE];
                end
                default: ;
            endcase
        end
    end

    // Read mux; the preset bit always reads as zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_RELOAD: rdata = reload;
            A_CTRL: begin
                rdata[CTL_RUN] = run;
                rdata[CTL_OEN] = oen;
            end
            A_IRQ: begin
                rdata[PW-1:0]   = prio;
                rdata[IRQ_IE]   = ie;
                rdata[IRQ_FLAG] = flag;
            end
            default: rdata = count;
        endcase
    end
endmodule

// File: rtl/reload_timer_counter.sv
`timescale 1ns/1ps
// Down-counter with reload. A preset loads the reload value and takes
// priority over a tick. While running, a tick at zero is an underflow and
// reloads. Assumes tick is a single-cycle pulse.
module reload_timer_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          preset,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] count,
    output logic          uflow
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // Underflow: a running tick at zero that is not overridden by a preset.
    assign uflow = tick && run && !preset && (count == '0);

    // Count register: preset, then decrement or reload on a running tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (preset) begin
            count <= reload;
        end else if (tick && run) begin
            count <= (count == '0) ? reload : count - ONE;
        end
    end
endmodule

// File: rtl/reload_timer_irq.sv
`timescale 1ns/1ps
// Underflow consequences: the factor flag (set wins over clear), the
// half-rate toggle with its output gate, and the prioritised request
// against the CPU mask. Assumes uflow and clr are single-cycle strobes.
module reload_timer_irq #(
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uflow,
    input  logic          clr,
    input  logic          oen,
    input  logic          ie,
    input  logic [PW-1:0] prio,
    input  logic [PW-1:0] mask,
    output logic          flag,
    output logic          tog,
    output logic          clk_out,
    output logic          req,
    output logic [PW-1:0] level
);
    // Factor flag: set on underflow, cleared by write-one, set dominates.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (uflow)  flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end

    // Divide-by-two toggle, flipping on every underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)     tog <= 1'b0;
        else if (uflow) tog <= ~tog;
    end

    // Output gate and request qualification.
    always_comb begin
        clk_out = tog && oen;
        req     = flag && ie && (prio > mask);
        level   = req ? prio : '0;
    end
endmodule

// File: rtl/reload_timer.sv
`timescale 1ns/1ps
// Top of the reloadable down-counter timer. It connects the register file,
// counter and interrupt/output logic. Everything runs on one clock with a
// synchronous active-low reset. The prescaler pulse arrives on cnt_tick.
module reload_timer
    import reload_timer_pkg::*;
#(
    parameter int CW = 8,
    parameter int PW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic [PW-1:0]    cpu_mask,
    input  logic             bus_we,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic [CW-1:0]    bus_wdata,
    output logic [CW-1:0]    bus_rdata,
    output logic             clk_out,
    output logic             irq_req,
    output logic [PW-1:0]    irq_level
);
    logic [CW-1:0] reload_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          oen_q;
    logic [PW-1:0] prio_q;
    logic          ie_q;
    logic          preset_stb;
    logic          clr_stb;
    logic          uflow;
    logic          flag_q;
    logic          tog_q;

    reload_timer_regs #(.CW(CW), .PW(PW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .count      (cnt_q),
        .flag       (flag_q),
        .rdata      (bus_rdata),
        .reload     (reload_q),
        .run        (run_q),
        .oen        (oen_q),
        .prio       (prio_q),
        .ie         (ie_q),
        .preset_stb (preset_stb),
        .clr_stb    (clr_stb)
    );

    reload_timer_counter #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (cnt_tick),
        .run    (run_q),
        .preset (preset_stb),
        .reload (reload_q),
        .count  (cnt_q),
        .uflow  (uflow)
    );

    reload_timer_irq #(.PW(PW)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .uflow   (uflow),
        .clr     (clr_stb),
        .oen     (oen_q),
        .ie      (ie_q),
        .prio    (prio_q),
        .mask    (cpu_mask),
        .flag    (flag_q),
        .tog     (tog_q),
        .clk_out (clk_out),
        .req     (irq_req),
        .level   (irq_level)
    );
endmodule

// File: rtl/reload_timer_checker.sv
`timescale 1ns/1ps
// Temporal checks on the timer, bound to its top module.
module reload_timer_checker #(
    parameter int CW = 8,
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_tick,
    input logic          run_q,
    input logic          preset_stb,
    input logic          clr_stb,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] reload_q,
    input logic          uflow,
    input logic          flag_q,
    input logic          tog_q,
    input logic          oen_q,
    input logic [PW-1:0] prio_q,
    input logic          clk_out,
    input logic          irq_req
);
    localparam logic [CW-1:0] ONE = CW'(1);

    p_preset_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        preset_stb |=> cnt_q == $past(reload_q));

    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !preset_stb) |=> $stable(cnt_q));

    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && run_q && !preset_stb && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);

    p_reload_on_uflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> cnt_q == $past(reload_q));

    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> tog_q != $past(tog_q));

    p_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !oen_q |-> !clk_out);

    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> flag_q);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && clr_stb) |=> flag_q);

    p_no_req_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (flag_q && prio_q != '0));

    p_preset_blocks_uflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        preset_stb |-> !uflow);
endmodule

bind reload_timer reload_timer_checker #(.CW(CW), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_tick   (cnt_tick),
    .run_q      (run_q),
    .preset_stb (preset_stb),
    .clr_stb    (clr_stb),
    .cnt_q      (cnt_q),
    .reload_q   (reload_q),
    .uflow      (uflow),
    .flag_q     (flag_q),
    .tog_q      (tog_q),
    .oen_q      (oen_q),
    .prio_q     (prio_q),
    .clk_out    (clk_out),
    .irq_req    (irq_req)
);

// File: tb/tb_reload_timer.sv
`timescale 1ns/1ps
// Self-checking bench: reload sweep with arithmetic expectations, an
// exhaustive priority/mask/enable sweep, and same-cycle collisions.
module tb_reload_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b0;
    logic [1:0] cpu_mask = 2'd0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       clk_out;
    logic       irq_req;
    logic [1:0] irq_level;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    int uflows  = 0;

    reload_timer dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cpu_mask(cpu_mask),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .clk_out(clk_out), .irq_req(irq_req),
        .irq_level(irq_level)
    );

    always #10 clk = ~clk; // 50 MHz

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_tick(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; cnt_tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; cnt_tick = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        cnt_tick = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // control value: bit0 run, bit1 preset, bit2 output enable
    function automatic logic [7:0] ctl(input bit run, input bit pre, input bit oen);
        return {5'd0, oen, pre, run};
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit oen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and output
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk("R1 reg", d, 0);
        end
        chk("R1 clk_out", clk_out, 0);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 irq_level", irq_level, 0);

        // R4/R5/R6: reload sweep, count = V - (k mod (V+1))
        for (int v = 0; v <= 10; v++) begin
            int rv = (v == 10) ? 255 : v;
            oen = (v % 2 == 0);
            wr(2'd1, ctl(0, 0, oen));
            wr(2'd2, 8'h08);                 // clear flag, ie=0, prio=0
            wr(2'd0, rv[7:0]);
            rd(2'd0, d);
            chk("R2 reload readback", d, rv);
            wr(2'd1, ctl(0, 1, oen));        // R2 preset
            rd(2'd3, d);
            chk("R2 preset count", d, rv);
            rd(2'd1, d);
            chk("R2 preset reads 0", d, {oen, 2'b00});
            wr(2'd1, ctl(1, 0, oen));
            for (int k = 1; k <= 2 * rv + 3; k++) begin
                tick();
                if (k % (rv + 1) == 0) uflows++;
                rd(2'd3, d);
                chk("R4 count", d, rv - (k % (rv + 1)));
                rd(2'd2, d);
                chk("R6 flag", d[3], (k >= rv + 1) ? 1 : 0);
                chk("R5 clk_out", clk_out, oen ? (uflows % 2) : 0);
                chk("R8 no req with ie=0", irq_req, 0);
            end
        end

        // R8: flag is 1 here; sweep prio x mask x enable (writes keep bit3=0)
        for (int ie = 0; ie < 2; ie++)
            for (int p = 0; p < 4; p++)
                for (int m = 0; m < 4; m++) begin
                    wr(2'd2, {5'd0, ie[0], p[1:0]});
                    cpu_mask = m[1:0];
                    #1;
                    chk("R8 irq_req", irq_req, (ie == 1 && p > m) ? 1 : 0);
                    chk("R8 irq_level", irq_level, (ie == 1 && p > m) ? p : 0);
                    rd(2'd2, d);
                    chk("R6 write-0 keeps flag", d[3], 1);
                end
        cpu_mask = 2'd0;
        wr(2'd2, 8'h0F);                     // clear flag, ie=1, prio=3
        rd(2'd2, d);
        chk("R6 w1c clears", d[3], 0);
        chk("R8 no req without flag", irq_req, 0);

        // R9: preset and tick together at count 0
        wr(2'd1, ctl(0, 0, 0));
        wr(2'd0, 8'd5);
        wr(2'd1, ctl(1, 1, 0));
        repeat (5) tick();
        rd(2'd3, d);
        chk("R9 setup count", d, 0);
        wr_tick(2'd1, ctl(1, 1, 0));
        rd(2'd3, d);
        chk("R9 preset wins", d, 5);
        rd(2'd2, d);
        chk("R9 no underflow", d[3], 0);

        // R7: clear write and underflow together
        repeat (5) tick();
        wr_tick(2'd2, 8'h0F);
        rd(2'd2, d);
        chk("R7 set wins", d[3], 1);
        chk("R7 irq raised", irq_req, 1);
        rd(2'd3, d);
        chk("R7 reloaded", d, 5);
        wr(2'd2, 8'h0F);
        rd(2'd2, d);
        chk("R7 plain clear", d[3], 0);

        // R3: stop holds, resume continues without reload
        repeat (2) tick();
        wr(2'd1, ctl(0, 0, 0));
        repeat (4) tick();
        rd(2'd3, d);
        chk("R3 held while stopped", d, 3);
        wr(2'd1, ctl(1, 0, 0));
        tick();
        rd(2'd3, d);
        chk("R3 resume", d, 2);
        wr(2'd1, ctl(0, 0, 0));
        wr(2'd0, 8'd20);
        wr(2'd1, ctl(0, 1, 0));
        wr(2'd1, ctl(0, 0, 0));              // R2 preset bit 0: no effect
        rd(2'd3, d);
        chk("R2 preset 0 ignored", d, 20);
        repeat (3) tick();
        rd(2'd3, d);
        chk("R3 preset held", d, 20);
        wr(2'd1, ctl(1, 0, 0));
        tick();
        rd(2'd3, d);
        chk("R3 start from preset", d, 19);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule